// File: doc/BRIEF.md
# Serial Test-Pattern Source with Error Injection

This block drives a serial test stream for bit-error-rate measurement, one bit each time the bit enable is high. Two stream kinds are available: a user word of up to 32 bits replayed with a programmable period, or a 15-stage maximal-length pseudorandom sequence. Errors can be placed in the stream on purpose, either automatically at one of seven decade rates or one at a time from a software-style trigger bit, so that the far-end checker's error counting can be proven.

Every stream bit that was deliberately inverted is marked by a one-cycle strobe beside the data, so a bench or a neighbouring counter knows exactly how many errors were injected. A change of the rate code or of the stream kind restarts the stream and the error spacing from a clean point.

Two state elements carry the control flow: a three-state machine for the single-error trigger, named ARMED (waiting for a high level after a low), PENDING (an error is owed to the next bit) and WAIT_LOW (owed error delivered or power-up, trigger must drop). Its transitions are: ARMED to PENDING when the trigger is high; PENDING to WAIT_LOW when a bit is emitted and the trigger is still high; PENDING to ARMED when a bit is emitted and the trigger is low; WAIT_LOW to ARMED when the trigger is low. All other cases stay put. Reset enters WAIT_LOW.

Top module: `bert_gen`

## Requirements
- R1: During and right after reset, `bit_out` and `err_flag` are 0.
- R2: In replay mode (`prbs_mode`=0) the stream after a restart is `pattern[0]`, `pattern[1]`, ... `pattern[L-1]`, then `pattern[0]` again, where L = `len_sel` + 17 (so 0 gives 17 bits, 15 gives 32).
- R3: A period shorter than 17 is obtained by filling the word with that period and picking L as a multiple of it (a 6-bit period with `len_sel`=1, L=18); the output then repeats every 6 bits.
- R4: In pseudorandom mode (`prbs_mode`=1) a 15-bit register, loaded with all ones on restart, gives its bit 14 as the stream bit and then shifts toward bit 14, bit 0 taking bit 14 XOR bit 13 (x^15+x^14+1); an all-zero state is replaced with all ones. The period is 32767 bits and `len_sel` has no effect.
- R5: A cycle with `bit_en`=0 does not advance the stream; `bit_out` holds and `err_flag` is 0.
- R6: `err_rate`=0 injects no automatic error; code n (1..7) inverts one bit in every 10^n emitted bits, the first being the 10^n-th bit after a restart, counting only emitted bits.
- R7: Each injected error inverts exactly one stream bit, and `err_flag` is 1 in the cycle in which that inverted bit is on `bit_out` and 0 otherwise.
- R8: A low-to-high change of `single_err` inverts exactly one later emitted bit (the first one emitted after the high level is seen); holding it high adds none, and it must go low and rise again for another. A level already high when reset ends does not count.
- R9: A single-error request and an automatic error falling on the same emitted bit give one inversion and one `err_flag` pulse.
- R10: In a cycle where `err_rate` or `prbs_mode` differs from its previous value, no bit is emitted; the replay index returns to 0, the pseudorandom register to all ones and the spacing counter to 10^n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | Emit one stream bit this cycle |
| prbs_mode | input | 1 | 1 selects the pseudorandom stream, 0 the replayed word |
| pattern | input | 32 | Word replayed from bit 0 upward |
| err_rate | input | 3 | Automatic error rate code, 0 off, n gives 1 in 10^n |
| single_err | input | 1 | Rising level requests one injected error |
| len_sel | input | 4 | Replay length minus 17 |
| bit_out | output | 1 | Serial stream bit |
| err_flag | output | 1 | High while `bit_out` carries an injected error |

## Verification
The single-error trigger and the automatic decade counter can both claim the same emitted bit. The bench restarts the spacing at a rate of one in ten, emits nine bits, raises the trigger while the enable is low so the request is owed, and then emits the tenth bit, where both fall together. It judges the case by counting `err_flag` pulses over those ten bits (exactly one) and by the per-clock reference model, which requires a single inversion of that bit; the next automatic error must still arrive ten bits later.

// File: rtl/bert_pkg.sv
package bert_pkg;

    localparam int PAT_W    = 32;
    localparam int LEN_W    = 4;
    localparam int LEN_BASE = 17;
    localparam int RATE_W   = 3;
    localparam int PRBS_W   = 15;
    localparam int CNT_W    = 24;
    localparam int IDX_W    = $clog2(PAT_W);

    localparam logic [PRBS_W-1:0] PRBS_SEED = '1;

    typedef enum logic [1:0] {
        SE_ARMED    = 2'd0,
        SE_PENDING  = 2'd1,
        SE_WAIT_LOW = 2'd2
    } se_state_t;

    // 10 to the power of the rate code; 0 when injection is off
    function automatic logic [CNT_W-1:0] decade(input logic [RATE_W-1:0] code);
        logic [CNT_W-1:0] v;
        v = (code == '0) ? '0 : CNT_W'(1);
        for (int k = 1; k < (1 << RATE_W); k++) begin
            if (k <= int'(code)) v = v * CNT_W'(10);
        end
        return v;
    endfunction

endpackage

// File: rtl/bert_pat_src.sv
module bert_pat_src
    import bert_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             emit,
    input  logic             restart,
    input  logic             prbs_mode,
    input  logic [LEN_W-1:0] len_sel,
    input  logic [PAT_W-1:0] pattern,
    output logic             raw_bit
);

    logic [IDX_W-1:0]  idx_q;
    logic [PRBS_W-1:0] lfsr_q;
    logic [PRBS_W-1:0] lfsr_step;
    logic [IDX_W-1:0]  last_idx;

    assign last_idx = IDX_W'(LEN_BASE - 1) + IDX_W'(len_sel);

    always_comb begin
        lfsr_step = {lfsr_q[PRBS_W-2:0], lfsr_q[PRBS_W-1] ^ lfsr_q[PRBS_W-2]};
        if (lfsr_step == '0) lfsr_step = PRBS_SEED;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q  <= '0;
            lfsr_q <= PRBS_SEED;
        end else if (restart) begin
            idx_q  <= '0;
            lfsr_q <= PRBS_SEED;
        end else if (emit) begin
            if (prbs_mode) begin
                lfsr_q <= lfsr_step;
            end else if (idx_q >= last_idx) begin
                idx_q <= '0;
            end else begin
                idx_q <= idx_q + IDX_W'(1);
            end
        end
    end

    assign raw_bit = prbs_mode ? lfsr_q[PRBS_W-1] : pattern[idx_q];

endmodule

// File: rtl/bert_rate_cnt.sv
module bert_rate_cnt
    import bert_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              emit,
    input  logic              restart,
    input  logic [RATE_W-1:0] rate,
    output logic              auto_due
);

    logic [CNT_W-1:0] cnt_q;
    logic             active;

    assign active   = (rate != '0);
    assign auto_due = emit && active && (cnt_q == CNT_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart) begin
            cnt_q <= decade(rate);
        end else if (emit && active) begin
            if (cnt_q <= CNT_W'(1)) cnt_q <= decade(rate);
            else                    cnt_q <= cnt_q - CNT_W'(1);
        end
    end

endmodule

// File: rtl/bert_single_fsm.sv
module bert_single_fsm
    import bert_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic single_err,
    input  logic emit,
    output logic se_pend,
    output logic se_wait
);

    se_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SE_WAIT_LOW;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SE_ARMED:    if (single_err) state_d = SE_PENDING;
            SE_PENDING:  if (emit) state_d = single_err ? SE_WAIT_LOW : SE_ARMED;
            SE_WAIT_LOW: if (!single_err) state_d = SE_ARMED;
            default:     state_d = SE_WAIT_LOW;
        endcase
    end

    always_comb begin
        se_pend = (state_q == SE_PENDING);
        se_wait = (state_q == SE_WAIT_LOW);
    end

endmodule

// File: rtl/bert_gen.sv
module bert_gen
    import bert_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic              prbs_mode,
    input  logic [PAT_W-1:0]  pattern,
    input  logic [RATE_W-1:0] err_rate,
    input  logic              single_err,
    input  logic [LEN_W-1:0]  len_sel,
    output logic              bit_out,
    output logic              err_flag
);

    logic [RATE_W-1:0] rate_q;
    logic              mode_q;
    logic              cfg_chg;
    logic              emit;
    logic              raw_bit;
    logic              auto_due;
    logic              se_pend;
    logic              se_wait;
    logic              inject;

    assign cfg_chg = (err_rate != rate_q) || (prbs_mode != mode_q);
    assign emit    = bit_en && !cfg_chg;
    assign inject  = auto_due || (se_pend && emit);

    bert_pat_src u_src (
        .clk       (clk),
        .rst_n     (rst_n),
        .emit      (emit),
        .restart   (cfg_chg),
        .prbs_mode (prbs_mode),
        .len_sel   (len_sel),
        .pattern   (pattern),
        .raw_bit   (raw_bit)
    );

    bert_rate_cnt u_rate (
        .clk      (clk),
        .rst_n    (rst_n),
        .emit     (emit),
        .restart  (cfg_chg),
        .rate     (err_rate),
        .auto_due (auto_due)
    );

    bert_single_fsm u_single (
        .clk        (clk),
        .rst_n      (rst_n),
        .single_err (single_err),
        .emit       (emit),
        .se_pend    (se_pend),
        .se_wait    (se_wait)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rate_q <= '0;
            mode_q <= 1'b0;
        end else begin
            rate_q <= err_rate;
            mode_q <= prbs_mode;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_out  <= 1'b0;
            err_flag <= 1'b0;
        end else begin
            err_flag <= emit && inject;
            if (emit) bit_out <= raw_bit ^ inject;
        end
    end

endmodule

// File: rtl/bert_gen_chk.sv
module bert_gen_chk
    import bert_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              bit_en,
    input logic [RATE_W-1:0] err_rate,
    input logic              single_err,
    input logic              bit_out,
    input logic              err_flag,
    input logic              raw_bit,
    input logic              auto_due,
    input logic              se_pend,
    input logic              se_wait,
    input logic              cfg_chg
);

    a_r5_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> ($stable(bit_out) && !err_flag));

    a_r7_flag_marks_inversion: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && !cfg_chg) |=> (err_flag == (bit_out != $past(raw_bit))));

    a_r6_off_no_auto: assert property (@(posedge clk) disable iff (!rst_n)
        (err_rate == '0) |-> !auto_due);

    a_r8_no_refire: assert property (@(posedge clk) disable iff (!rst_n)
        (se_wait && single_err) |=> !se_pend);

    a_r10_restart_silent: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_chg |=> (!err_flag && $stable(bit_out)));

endmodule

bind bert_gen bert_gen_chk u_chk (.*);

// File: tb/bert_gen_bench.sv
module bert_gen_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_en = 1'b0;
    logic        prbs_mode = 1'b0;
    logic [31:0] pattern = 32'h0;
    logic [2:0]  err_rate = 3'd0;
    logic        single_err = 1'b0;
    logic [3:0]  len_sel = 4'd0;
    logic        bit_out;
    logic        err_flag;

    int n_chk = 0;
    int n_bad = 0;
    int errs = 0;
    int cycles = 0;
    bit done = 1'b0;
    string tag = "R1";
    bit got[$];

    always #2.5 clk = ~clk;

    bert_gen u_bert_gen (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .prbs_mode(prbs_mode),
        .pattern(pattern), .err_rate(err_rate), .single_err(single_err),
        .len_sel(len_sel), .bit_out(bit_out), .err_flag(err_flag)
    );

    // behavioural reference model
    int m_prev_rate, m_prev_mode, m_idx, m_lfsr, m_cnt, m_se, m_bo, m_ef;

    function automatic int pow10(int n);
        int p = (n == 0) ? 0 : 1;
        for (int k = 0; k < n; k++) p = p * 10;
        return p;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_prev_rate = 0; m_prev_mode = 0; m_idx = 0; m_lfsr = 32767;
            m_cnt = 0; m_se = 2; m_bo = 0; m_ef = 0;
        end else begin
            bit sing_now;
            sing_now = 1'b0;
            if (int'(err_rate) != m_prev_rate || int'(prbs_mode) != m_prev_mode) begin
                m_prev_rate = err_rate; m_prev_mode = prbs_mode;
                m_idx = 0; m_lfsr = 32767; m_cnt = pow10(err_rate); m_ef = 0;
            end else if (bit_en) begin
                int raw, inv;
                raw = prbs_mode ? ((m_lfsr >> 14) & 1) : int'(pattern[m_idx]);
                inv = ((err_rate != 0 && m_cnt == 1) || m_se == 1) ? 1 : 0;
                m_bo = raw ^ inv; m_ef = inv;
                sing_now = (m_se == 1);
                if (prbs_mode) begin
                    m_lfsr = ((m_lfsr << 1) & 32767) | (((m_lfsr >> 14) ^ (m_lfsr >> 13)) & 1);
                    if (m_lfsr == 0) m_lfsr = 32767;
                end else begin
                    m_idx = (m_idx >= 16 + int'(len_sel)) ? 0 : m_idx + 1;
                end
                if (err_rate != 0) m_cnt = (m_cnt <= 1) ? pow10(err_rate) : m_cnt - 1;
            end else begin
                m_ef = 0;
            end
            if (sing_now)                  m_se = single_err ? 2 : 0;
            else if (m_se == 0 && single_err) m_se = 1;
            else if (m_se == 2 && !single_err) m_se = 0;
        end
    end

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check({tag, " bit_out"}, int'(bit_out), m_bo);
            check({tag, " err_flag"}, int'(err_flag), m_ef);
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000 && !done) begin
            done = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=<190000 cycles", cycles);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    task automatic idle(int n);
        bit_en = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic run_bits(int n);
        bit_en = 1'b1;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            got.push_back(bit_out);
            errs += int'(err_flag);
        end
        bit_en = 1'b0;
    endtask

    initial begin
        bit first[$];
        logic [31:0] w6;
        repeat (3) @(negedge clk);
        tag = "R1";
        check("R1 bit_out in reset", int'(bit_out), 0);
        check("R1 err_flag in reset", int'(err_flag), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 bit_out after reset", int'(bit_out), 0);

        // R2: length 17
        tag = "R2";
        pattern = 32'hA5C3_96E1; len_sel = 4'd0;
        got.delete(); run_bits(51);
        for (int i = 0; i < 51; i++) check("R2 len17 bit", int'(got[i]), int'(pattern[i % 17]));

        // R2: length 32 via restart through mode toggle
        prbs_mode = 1'b1; idle(2); prbs_mode = 1'b0; idle(2);
        len_sel = 4'd15; pattern = 32'h1357_9BDF;
        got.delete(); run_bits(70);
        for (int i = 0; i < 70; i++) check("R2 len32 bit", int'(got[i]), int'(pattern[i % 32]));

        // R5: hold with bit_en low
        tag = "R5";
        idle(1);
        begin
            logic held;
            held = bit_out;
            idle(6);
            check("R5 bit_out held", int'(bit_out), int'(held));
            check("R5 err_flag low", int'(err_flag), 0);
        end

        // R3: 6-bit period in an 18-bit length
        tag = "R3";
        w6 = '0;
        for (int i = 0; i < 18; i++) w6[i] = (6'b101100 >> (i % 6)) & 1;
        prbs_mode = 1'b1; idle(2); prbs_mode = 1'b0; idle(2);
        pattern = w6; len_sel = 4'd1;
        got.delete();
        for (int k = 0; k < 12; k++) begin run_bits(6); idle(k % 3); end
        for (int i = 0; i < 66; i++) check("R3 period 6", int'(got[i + 6]), int'(got[i]));

        // R4: pseudorandom, period and len_sel ignored
        tag = "R4";
        prbs_mode = 1'b1; idle(2);
        got.delete(); run_bits(40);
        for (int i = 0; i < 15; i++) check("R4 seed ones", int'(got[i]), 1);
        first = got;
        len_sel = 4'd7;
        run_bits(32767 - 40);
        len_sel = 4'd2;
        got.delete(); run_bits(40);
        for (int i = 0; i < 40; i++) check("R4 period 32767", int'(got[i]), int'(first[i]));

        // R6/R7: decade rates
        tag = "R6";
        prbs_mode = 1'b0; len_sel = 4'd3; idle(2);
        err_rate = 3'd1; idle(2); errs = 0; run_bits(200);
        check("R6 rate1 errors in 200", errs, 20);
        err_rate = 3'd2; idle(2); errs = 0; run_bits(350);
        check("R6 rate2 errors in 350", errs, 3);
        err_rate = 3'd3; idle(2); errs = 0; run_bits(999);
        check("R6 rate3 none before 1000th", errs, 0);
        run_bits(1); check("R6 rate3 at 1000th", errs, 1);
        err_rate = 3'd7; idle(2); errs = 0; run_bits(500);
        check("R6 rate7 none in 500", errs, 0);
        err_rate = 3'd0; idle(2); errs = 0; run_bits(300);
        check("R6 rate0 none", errs, 0);

        // R8: single trigger
        tag = "R8";
        single_err = 1'b1; idle(2); errs = 0; run_bits(5);
        check("R8 one error on rise", errs, 1);
        errs = 0; run_bits(8);
        check("R8 held high no more", errs, 0);
        single_err = 1'b0; idle(2); single_err = 1'b1; idle(1);
        errs = 0; run_bits(3);
        check("R8 second rise", errs, 1);
        single_err = 1'b0; idle(2);

        // R9: coincidence of single and automatic
        tag = "R9";
        err_rate = 3'd1; idle(2); errs = 0;
        run_bits(9);
        check("R9 none before 10th", errs, 0);
        single_err = 1'b1; idle(2);
        run_bits(1);
        check("R9 one inversion on shared bit", errs, 1);
        single_err = 1'b0; idle(1); errs = 0;
        run_bits(10);
        check("R9 next auto 10 later", errs, 1);

        // R10: change with bit_en held high emits nothing
        tag = "R10";
        bit_en = 1'b1; err_rate = 3'd2;
        @(negedge clk);
        check("R10 no flag on change", int'(err_flag), 0);
        bit_en = 1'b0; err_rate = 3'd0; idle(2);
        got.delete(); run_bits(17);
        for (int i = 0; i < 17; i++) check("R10 index restarted", int'(got[i]), int'(pattern[i]));
        idle(2);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule